// File: doc/BRIEF.md
# Registry Directory Bank

This block is one bank of the shared last-level store for a group of cores. The bank keeps no sharer lists. Each word entry does double duty. A per-word flag says whether the entry holds the current data value or the number of the core that has the word registered. Data read misses, write and synchronization registrations, and write-backs from N cores are arbitrated round-robin. At most one request is accepted per cycle.

A request that finds the data in the bank is answered on the next cycle. A read of a registered word becomes a forward to the registrant, which returns its up-to-date copy. The bank then passes that copy to the reader.

A synchronization read of a registered word also moves the registration to the reader. The old registrant drops its copy when it answers the forward. Registrations and write-backs only rewrite the entry. No invalidation or acknowledgement traffic is ever produced.

While a forward is outstanding, its word is locked against new requests. The requesting core also waits until the forward completes.

Top module: `registry_dir`

## Requirements
- R1: After reset every word holds valid data equal to zero, and `rsp_valid`, `fwd_valid` and `req_grant` are all low.
- R2: A data read (`req_op`=0) of a word holding data gets `rsp_valid` for that core one cycle after its grant, with the stored value, and the entry is not changed.
- R3: A registration or write request (`req_op`=1) records the requester as registrant and is acknowledged one cycle after grant with data 0. Any later read of that word is forwarded to that core.
- R4: A data read of a registered word raises `fwd_valid` one cycle after grant, with `fwd_owner` = registrant, `fwd_addr` = word and `fwd_xfer`=0. The response to the reader comes one cycle after `fwd_done` and carries `fwd_done_data`. The registrant is unchanged.
- R5: A synchronization read (`req_op`=2) of a word holding data returns that data one cycle after grant and makes the reader the registrant.
- R6: A synchronization read of a word registered to another core forwards with `fwd_xfer`=1. On completion the reader gets `fwd_done_data` and becomes the registrant.
- R7: A write-back (`req_op`=3) from the registrant puts its data back into the entry as valid data. A write-back from any other core is acknowledged but leaves the entry unchanged.
- R8: Requests are granted one per cycle in round-robin order, starting from the core after the last one granted (core 0 first after reset).
- R9: A request to a word with a pending forward is not granted until that forward completes. Requests to other words are still granted meanwhile.
- R10: In a cycle with `fwd_done` high no request is granted, so at most one `rsp_valid` bit is ever high.
- R11: Registrations and write-backs never raise `fwd_valid`. Each forward follows exactly one granted read or synchronization read of a registered word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | N_CORES | Per-core request, held until granted |
| req_op | input | 2*N_CORES | Per-core opcode: 0 read, 1 register/write, 2 sync read, 3 write-back |
| req_addr | input | ADDR_W*N_CORES | Per-core word address |
| req_data | input | DATA_W*N_CORES | Per-core write-back data |
| req_grant | output | N_CORES | Combinational grant, one-hot or zero |
| rsp_valid | output | N_CORES | Per-core response strobe |
| rsp_data | output | DATA_W*N_CORES | Per-core response data |
| fwd_valid | output | 1 | Forward request to a registrant |
| fwd_owner | output | ID_W | Core that must answer the forward |
| fwd_addr | output | ADDR_W | Word being forwarded |
| fwd_tag | output | TAG_W | Slot tag to return on completion |
| fwd_xfer | output | 1 | Registration moves to the reader; owner drops its copy |
| fwd_done | input | 1 | Registrant answers a forward |
| fwd_done_tag | input | TAG_W | Tag of the forward being answered |
| fwd_done_data | input | DATA_W | Up-to-date word from the registrant |

## Verification
A grant is combinational in the cycle a held request wins. A direct response and a forward both appear on the registered outputs one cycle after that grant. A forwarded response appears one cycle after the `fwd_done` cycle.

The bench changes inputs on the falling edge and reads `req_grant` 1 ns later, in the same cycle. When a grant is seen it queues the expected response. The scoreboard monitor compares `rsp_valid`/`rsp_data` at the next falling edge, and the forward fields are read at that same edge.

Blocking and the completion-cycle stall are checked by watching `req_grant` stay low in the exact cycles concerned. A `fwd_valid` seen while none is due is flagged as a failure.

// File: rtl/registry_dir_pkg.sv
package registry_dir_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_REG  = 2'd1,
    OP_SYNC = 2'd2,
    OP_WB   = 2'd3
  } dir_op_e;

endpackage

// File: rtl/dir_rst_sync.sv
module dir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dir_rr_arbiter.sv
module dir_rr_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, ptr_d;
  logic          hit;

  always_comb begin
    int idx;
    grant = '0;
    ptr_d = ptr_q;
    hit   = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!hit && en && req[idx]) begin
        grant[idx] = 1'b1;
        hit        = 1'b1;
        ptr_d      = IW'((idx + 1) % N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (hit) ptr_q <= ptr_d;
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) else $error("grant not one-hot");

  // R8
  grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~req) == '0)) else $error("grant without request");
endmodule

// File: rtl/dir_entry_store.sv
module dir_entry_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_reg,
  output logic [DATA_W-1:0] rd_pay,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_reg,
  input  logic [DATA_W-1:0] wr_pay
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              reg_q [DEPTH];
  logic [DATA_W-1:0] pay_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_word
    logic sel;
    assign sel = we && (wr_addr == ADDR_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[e] <= 1'b0;
        pay_q[e] <= '0;
      end else if (sel) begin
        reg_q[e] <= wr_reg;
        pay_q[e] <= wr_pay;
      end
    end
  end

  assign rd_reg = reg_q[rd_addr];
  assign rd_pay = pay_q[rd_addr];
endmodule

// File: rtl/dir_fwd_table.sv
module dir_fwd_table #(
  parameter int N      = 4,
  parameter int SLOTS  = 2,
  parameter int ADDR_W = 4,
  parameter int ID_W   = 2,
  parameter int TAG_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [ID_W-1:0]   alloc_rid,
  input  logic              alloc_xfer,
  output logic [TAG_W-1:0]  free_tag,
  output logic              full,
  input  logic              done,
  input  logic [TAG_W-1:0]  done_tag,
  output logic [ADDR_W-1:0] done_addr,
  output logic [ID_W-1:0]   done_rid,
  output logic              done_xfer,
  input  logic [N*ADDR_W-1:0] core_addr,
  output logic [N-1:0]      busy,
  output logic [N-1:0]      blocked
);
  logic [SLOTS-1:0]  v_q;
  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [ID_W-1:0]   rid_q  [SLOTS];
  logic              xfer_q [SLOTS];

  always_comb begin
    logic got;
    got      = 1'b0;
    free_tag = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!got && !v_q[s]) begin
        free_tag = TAG_W'(s);
        got      = 1'b1;
      end
    end
  end
  assign full = &v_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic set_s, clr_s;
    assign set_s = alloc && (free_tag == TAG_W'(s));
    assign clr_s = done && (done_tag == TAG_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     v_q[s] <= 1'b0;
      else if (set_s) v_q[s] <= 1'b1;
      else if (clr_s) v_q[s] <= 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[s] <= '0;
        rid_q[s]  <= '0;
        xfer_q[s] <= 1'b0;
      end else if (set_s) begin
        addr_q[s] <= alloc_addr;
        rid_q[s]  <= alloc_rid;
        xfer_q[s] <= alloc_xfer;
      end
    end
  end

  assign done_addr = addr_q[done_tag];
  assign done_rid  = rid_q[done_tag];
  assign done_xfer = xfer_q[done_tag];

  for (genvar c = 0; c < N; c++) begin : g_core
    always_comb begin
      busy[c]    = 1'b0;
      blocked[c] = 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
        if (v_q[s] && rid_q[s] == ID_W'(c)) busy[c] = 1'b1;
        if (v_q[s] && addr_q[s] == core_addr[c*ADDR_W +: ADDR_W]) blocked[c] = 1'b1;
      end
    end
  end

  // R4
  done_tag_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> v_q[done_tag]) else $error("completion for idle slot");

  // R9
  for (genvar a = 0; a < SLOTS; a++) begin : g_ua
    for (genvar b = a + 1; b < SLOTS; b++) begin : g_ub
      unique_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(v_q[a] && v_q[b] && addr_q[a] == addr_q[b]))
        else $error("two forwards pending on one word");
    end
  end
endmodule

// File: rtl/registry_dir.sv
module registry_dir
  import registry_dir_pkg::*;
#(
  parameter int N_CORES   = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int FWD_SLOTS = 2,
  localparam int ID_W     = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int TAG_W    = (FWD_SLOTS > 1) ? $clog2(FWD_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CORES-1:0]          req_valid,
  input  logic [2*N_CORES-1:0]        req_op,
  input  logic [ADDR_W*N_CORES-1:0]   req_addr,
  input  logic [DATA_W*N_CORES-1:0]   req_data,
  output logic [N_CORES-1:0]          req_grant,
  output logic [N_CORES-1:0]          rsp_valid,
  output logic [DATA_W*N_CORES-1:0]   rsp_data,
  output logic                        fwd_valid,
  output logic [ID_W-1:0]             fwd_owner,
  output logic [ADDR_W-1:0]           fwd_addr,
  output logic [TAG_W-1:0]            fwd_tag,
  output logic                        fwd_xfer,
  input  logic                        fwd_done,
  input  logic [TAG_W-1:0]            fwd_done_tag,
  input  logic [DATA_W-1:0]           fwd_done_data
);
  logic rst_ls;
  dir_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ls));

  // table and arbitration
  logic [N_CORES-1:0] busy, blocked, elig, grant;
  logic               tbl_full, alloc, done_xfer;
  logic [TAG_W-1:0]   free_tag;
  logic [ADDR_W-1:0]  done_addr;
  logic [ID_W-1:0]    done_rid;
  logic               arb_en;

  logic               gnt_any;
  logic [ID_W-1:0]    gnt_id;
  dir_op_e            gnt_op;
  logic [ADDR_W-1:0]  gnt_addr;
  logic [DATA_W-1:0]  gnt_data;

  assign elig   = req_valid & ~busy & ~blocked;
  assign arb_en = !fwd_done && !tbl_full;

  dir_rr_arbiter #(.N(N_CORES)) u_arb (
    .clk(clk), .rst_n(rst_ls), .en(arb_en), .req(elig), .grant(grant)
  );
  assign req_grant = grant;

  always_comb begin
    gnt_any  = |grant;
    gnt_id   = '0;
    gnt_op   = OP_READ;
    gnt_addr = '0;
    gnt_data = '0;
    for (int i = 0; i < N_CORES; i++) begin
      if (grant[i]) begin
        gnt_id   = ID_W'(i);
        gnt_op   = dir_op_e'(req_op[2*i +: 2]);
        gnt_addr = req_addr[i*ADDR_W +: ADDR_W];
        gnt_data = req_data[i*DATA_W +: DATA_W];
      end
    end
  end

  // word store
  logic              rd_reg;
  logic [DATA_W-1:0] rd_pay;
  logic              st_we, st_wreg;
  logic [ADDR_W-1:0] st_wa;
  logic [DATA_W-1:0] st_wpay;

  dir_entry_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_ls), .rd_addr(gnt_addr), .rd_reg(rd_reg), .rd_pay(rd_pay),
    .we(st_we), .wr_addr(st_wa), .wr_reg(st_wreg), .wr_pay(st_wpay)
  );

  dir_fwd_table #(.N(N_CORES), .SLOTS(FWD_SLOTS), .ADDR_W(ADDR_W), .ID_W(ID_W),
                  .TAG_W(TAG_W)) u_tbl (
    .clk(clk), .rst_n(rst_ls),
    .alloc(alloc), .alloc_addr(gnt_addr), .alloc_rid(gnt_id),
    .alloc_xfer(gnt_op == OP_SYNC), .free_tag(free_tag), .full(tbl_full),
    .done(fwd_done), .done_tag(fwd_done_tag), .done_addr(done_addr),
    .done_rid(done_rid), .done_xfer(done_xfer),
    .core_addr(req_addr), .busy(busy), .blocked(blocked)
  );

  // next state
  logic [N_CORES-1:0]        rsp_v_d;
  logic [DATA_W*N_CORES-1:0] rsp_d_d;
  logic                      fwd_v_d, fwd_x_d;
  logic [ID_W-1:0]           fwd_o_d;
  logic [ADDR_W-1:0]         fwd_a_d;
  logic [TAG_W-1:0]          fwd_t_d;
  logic [ID_W-1:0]           owner_id;
  logic                      own_match;

  assign owner_id  = rd_pay[ID_W-1:0];
  assign own_match = rd_reg && (owner_id == gnt_id);

  always_comb begin
    st_we   = 1'b0;
    st_wa   = gnt_addr;
    st_wreg = 1'b0;
    st_wpay = '0;
    rsp_v_d = '0;
    rsp_d_d = '0;
    fwd_v_d = 1'b0;
    fwd_x_d = (gnt_op == OP_SYNC);
    fwd_o_d = owner_id;
    fwd_a_d = gnt_addr;
    fwd_t_d = free_tag;
    alloc   = 1'b0;
    if (fwd_done) begin
      st_wa = done_addr;
      if (done_xfer) begin
        st_we   = 1'b1;
        st_wreg = 1'b1;
        st_wpay = {{(DATA_W-ID_W){1'b0}}, done_rid};
      end
      rsp_v_d[done_rid]                   = 1'b1;
      rsp_d_d[done_rid*DATA_W +: DATA_W]  = fwd_done_data;
    end else if (gnt_any) begin
      unique case (gnt_op)
        OP_READ, OP_SYNC: begin
          if (rd_reg) begin
            fwd_v_d = 1'b1;
            alloc   = 1'b1;
          end else begin
            rsp_v_d[gnt_id]                  = 1'b1;
            rsp_d_d[gnt_id*DATA_W +: DATA_W] = rd_pay;
            if (gnt_op == OP_SYNC) begin
              st_we   = 1'b1;
              st_wreg = 1'b1;
              st_wpay = {{(DATA_W-ID_W){1'b0}}, gnt_id};
            end
          end
        end
        OP_REG: begin
          st_we           = 1'b1;
          st_wreg         = 1'b1;
          st_wpay         = {{(DATA_W-ID_W){1'b0}}, gnt_id};
          rsp_v_d[gnt_id] = 1'b1;
        end
        OP_WB: begin
          if (own_match) begin
            st_we   = 1'b1;
            st_wreg = 1'b0;
            st_wpay = gnt_data;
          end
          rsp_v_d[gnt_id] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_ls) begin
    if (!rst_ls) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
      fwd_valid <= 1'b0;
      fwd_owner <= '0;
      fwd_addr  <= '0;
      fwd_tag   <= '0;
      fwd_xfer  <= 1'b0;
    end else begin
      rsp_valid <= rsp_v_d;
      rsp_data  <= rsp_d_d;
      fwd_valid <= fwd_v_d;
      if (fwd_v_d) begin
        fwd_owner <= fwd_o_d;
        fwd_addr  <= fwd_a_d;
        fwd_tag   <= fwd_t_d;
        fwd_xfer  <= fwd_x_d;
      end
    end
  end

  // R10
  single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    $onehot0(rsp_valid)) else $error("two responses in one cycle");

  // R11
  fwd_from_read_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    fwd_valid |-> ($past(gnt_any) && ($past(gnt_op) == OP_READ || $past(gnt_op) == OP_SYNC)))
    else $error("forward not caused by a granted read");

  // R9
  grant_not_blocked_chk: assert property (@(posedge clk) disable iff (!rst_ls)
    ((grant & blocked) == '0)) else $error("grant to a locked word");
endmodule

// File: tb/registry_dir_tb_top.sv
module registry_dir_tb_top;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int TW = 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_data = '0;
  logic [N-1:0]    req_grant;
  logic [N-1:0]    rsp_valid;
  logic [DW*N-1:0] rsp_data;
  logic            fwd_valid;
  logic [1:0]      fwd_owner;
  logic [AW-1:0]   fwd_addr;
  logic [TW-1:0]   fwd_tag;
  logic            fwd_xfer;
  logic            fwd_done = 1'b0;
  logic [TW-1:0]   fwd_done_tag = '0;
  logic [DW-1:0]   fwd_done_data = '0;

  always #5 clk = ~clk;

  registry_dir dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_grant(req_grant),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fwd_valid(fwd_valid),
    .fwd_owner(fwd_owner), .fwd_addr(fwd_addr), .fwd_tag(fwd_tag),
    .fwd_xfer(fwd_xfer), .fwd_done(fwd_done), .fwd_done_tag(fwd_done_tag),
    .fwd_done_data(fwd_done_data)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit live  = 1'b0;
  bit fwd_wait = 1'b0;

  int      q_core [$];
  int      q_data [$];
  string   q_tag  [$];

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic push_exp(input int c, input int d, input string rq);
    q_core.push_back(c);
    q_data.push_back(d);
    q_tag.push_back(rq);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (live) begin
      for (int i = 0; i < N; i++) begin
        if (rsp_valid[i]) begin
          if (q_core.size() == 0) begin
            check(1'b0, "R2 unexpected response", i, -1);
          end else begin
            int ec, ed;
            string et;
            ec = q_core.pop_front();
            ed = q_data.pop_front();
            et = q_tag.pop_front();
            check(ec == i, et, i, ec);
            check(int'(rsp_data[i*DW +: DW]) == ed, et, int'(rsp_data[i*DW +: DW]), ed);
          end
        end
      end
      if (fwd_valid && !fwd_wait) check(1'b0, "R11 stray forward", 1, 0);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive(input int c, input int op, input int a, input int d);
    req_op[2*c +: 2]     = 2'(op);
    req_addr[c*AW +: AW] = AW'(a);
    req_data[c*DW +: DW] = DW'(d);
    req_valid[c]         = 1'b1;
  endtask

  task automatic do_req(input int c, input int op, input int a, input int d,
                        input bit exp_rsp, input int exp_d, input bit want_fwd,
                        input string rq);
    int waited;
    @(negedge clk);
    drive(c, op, a, d);
    waited = 0;
    #1;
    while (!req_grant[c] && waited < 50) begin
      @(negedge clk);
      #1;
      waited++;
    end
    check(req_grant[c] == 1'b1, {rq, " grant"}, int'(req_grant), 1 << c);
    if (exp_rsp) push_exp(c, exp_d, rq);
    if (want_fwd) fwd_wait = 1'b1;
    @(negedge clk);
    req_valid[c] = 1'b0;
  endtask

  task automatic expect_fwd(input int owner, input int a, input bit x,
                            input string rq, output logic [TW-1:0] tag);
    int waited = 0;
    #1;
    while (!fwd_valid && waited < 20) begin
      @(negedge clk);
      #1;
      waited++;
    end
    check(fwd_valid == 1'b1, {rq, " fwd_valid"}, int'(fwd_valid), 1);
    check(int'(fwd_owner) == owner, {rq, " fwd_owner"}, int'(fwd_owner), owner);
    check(int'(fwd_addr) == a, {rq, " fwd_addr"}, int'(fwd_addr), a);
    check(fwd_xfer == x, {rq, " fwd_xfer"}, int'(fwd_xfer), int'(x));
    tag = fwd_tag;
    fwd_wait = 1'b0;
  endtask

  task automatic complete(input logic [TW-1:0] tag, input int d, input int reader,
                          input string rq);
    @(negedge clk);
    fwd_done      = 1'b1;
    fwd_done_tag  = tag;
    fwd_done_data = DW'(d);
    push_exp(reader, d, rq);
    @(negedge clk);
    fwd_done = 1'b0;
  endtask

  task automatic set_word(input int c, input int a, input int d);
    do_req(c, 1, a, 0, 1'b1, 0, 1'b0, "R3 register");
    do_req(c, 3, a, d, 1'b1, 0, 1'b0, "R7 write-back");
  endtask

  task automatic burst(input logic [N-1:0] mask, input int o0, input int o1,
                       input int o2, input int o3, input int cnt);
    int order [4];
    order = '{o0, o1, o2, o3};
    @(negedge clk);
    for (int i = 0; i < N; i++) if (mask[i]) drive(i, 0, 8 + i, 0);
    for (int k = 0; k < cnt; k++) begin
      #1;
      check(req_grant == N'(1 << order[k]), "R8 round-robin order",
            int'(req_grant), 1 << order[k]);
      push_exp(order[k], 16'h0800 + order[k], "R8 burst data");
      @(negedge clk);
      req_valid[order[k]] = 1'b0;
    end
  endtask

  initial begin
    logic [TW-1:0] t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(rsp_valid == '0, "R1 rsp_valid idle", int'(rsp_valid), 0);
    check(fwd_valid == 1'b0, "R1 fwd_valid idle", int'(fwd_valid), 0);
    check(req_grant == '0, "R1 no grant", int'(req_grant), 0);
    live = 1'b1;
    do_req(1, 0, 0, 0, 1'b1, 0, 1'b0, "R1 word 0 zero");
    do_req(2, 0, 15, 0, 1'b1, 0, 1'b0, "R1 word 15 zero");

    // R2 direct reads
    set_word(0, 3, 16'h3333);
    do_req(2, 0, 3, 0, 1'b1, 16'h3333, 1'b0, "R2 read data");
    do_req(1, 0, 3, 0, 1'b1, 16'h3333, 1'b0, "R2 read unchanged");

    // R8 round-robin
    for (int i = 0; i < N; i++) set_word(i, 8 + i, 16'h0800 + i);
    do_req(3, 0, 11, 0, 1'b1, 16'h0803, 1'b0, "R8 pointer setup");
    burst(4'b1111, 0, 1, 2, 3, 4);
    do_req(1, 0, 9, 0, 1'b1, 16'h0801, 1'b0, "R8 pointer setup");
    burst(4'b1011, 3, 0, 1, 0, 3);

    // R3 / R4 / R9 / R10
    do_req(0, 1, 5, 0, 1'b1, 0, 1'b0, "R3 register word 5");
    do_req(1, 0, 5, 0, 1'b0, 0, 1'b1, "R4 read registered");
    expect_fwd(0, 5, 1'b0, "R4 forward", t);
    @(negedge clk);
    drive(2, 0, 5, 0);
    drive(3, 0, 6, 0);
    #1;
    check(req_grant == 4'b1000, "R9 other word proceeds", int'(req_grant), 8);
    push_exp(3, 0, "R9 other word data");
    @(negedge clk);
    req_valid[3] = 1'b0;
    for (int k = 0; k < 2; k++) begin
      #1;
      check(req_grant[2] == 1'b0, "R9 locked word waits", int'(req_grant), 0);
      @(negedge clk);
    end
    fwd_done      = 1'b1;
    fwd_done_tag  = t;
    fwd_done_data = 16'hBEEF;
    push_exp(1, 16'hBEEF, "R4 forwarded data");
    drive(0, 0, 6, 0);
    #1;
    check(req_grant == '0, "R10 no grant on completion", int'(req_grant), 0);
    @(negedge clk);
    fwd_done = 1'b0;
    #1;
    check(req_grant == 4'b0001, "R8 grant after stall", int'(req_grant), 1);
    push_exp(0, 0, "R10 delayed read data");
    @(negedge clk);
    req_valid[0] = 1'b0;
    #1;
    check(req_grant == 4'b0100, "R9 released word granted", int'(req_grant), 4);
    fwd_wait = 1'b1;
    @(negedge clk);
    req_valid[2] = 1'b0;
    expect_fwd(0, 5, 1'b0, "R4 registrant kept", t);
    complete(t, 16'h1234, 2, "R4 second forward data");

    // R6 registration transfer
    do_req(1, 2, 5, 0, 1'b0, 0, 1'b1, "R6 sync read registered");
    expect_fwd(0, 5, 1'b1, "R6 transfer forward", t);
    complete(t, 16'h0A0A, 1, "R6 transfer data");
    do_req(2, 0, 5, 0, 1'b0, 0, 1'b1, "R6 new registrant");
    expect_fwd(1, 5, 1'b0, "R6 forward to new registrant", t);
    complete(t, 16'h0B0B, 2, "R6 data");

    // R7 write-backs
    do_req(2, 3, 5, 16'h7777, 1'b1, 0, 1'b0, "R7 foreign write-back ack");
    do_req(3, 0, 5, 0, 1'b0, 0, 1'b1, "R7 foreign write-back ignored");
    expect_fwd(1, 5, 1'b0, "R7 still registered", t);
    complete(t, 16'h0C0C, 3, "R7 data");
    do_req(1, 3, 5, 16'h4242, 1'b1, 0, 1'b0, "R7 owner write-back ack");
    do_req(0, 0, 5, 0, 1'b1, 16'h4242, 1'b0, "R7 data restored");

    // R5 sync read of data
    set_word(0, 9, 16'h0909);
    do_req(2, 2, 9, 0, 1'b1, 16'h0909, 1'b0, "R5 sync read data");
    do_req(3, 0, 9, 0, 1'b0, 0, 1'b1, "R5 reader registered");
    expect_fwd(2, 9, 1'b0, "R5 forward to reader", t);
    complete(t, 16'h0D0D, 3, "R5 data");

    // R11 registration over a registered word: no forward
    do_req(3, 1, 9, 0, 1'b1, 0, 1'b0, "R11 register no forward");
    repeat (3) @(negedge clk);
    do_req(0, 0, 9, 0, 1'b0, 0, 1'b1, "R3 new registrant");
    expect_fwd(3, 9, 1'b0, "R3 forward to registrant", t);
    complete(t, 16'h0E0E, 0, "R3 data");

    repeat (4) @(negedge clk);
    check(q_core.size() == 0, "R2 all responses seen", q_core.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule